// File: doc/BRIEF.md
# Reference Frequency Selector with Inhibit

This block divides a fixed crystal-derived clock down to the comparison frequency of a frequency synthesizer loop. A 4-bit select code chooses one of ten comparison rates between 1 kHz and 100 kHz. Two pairs of codes select the same rate. The four top codes put the loop into a backup state, where no comparison pulses are produced.

Each output period is a single-cycle pulse, which goes to the phase detector. The inhibit flag is used by the surrounding logic for two things: it disables the feedback divider, with its inputs held low, and it floats the charge pump output. When the code changes, the divider restarts from zero, so the first pulse of the new rate arrives a full new period after the change. The input clock frequency is a parameter with a default of 7.2 MHz. With that default the divide ratios run from 72 up to 7200.

Top module: `ref_freq_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `ref_o` is 0 and `inhibit_o` is 1, because the reset code is 4'hF.
- R2: Codes 4'h0, 4'h1, 4'h2, 4'h4, 4'h5 and 4'h6 give pulse periods of CLK_HZ/100 kHz, /50 kHz, /25 kHz, /12.5 kHz, /6.25 kHz and /3.125 kHz input cycles. With the default clock these periods are 72, 144, 288, 576, 1152 and 2304 cycles.
- R3: Codes 4'h8, 4'h9, 4'hA and 4'hB give periods of CLK_HZ/10 kHz, /9 kHz, /5 kHz and /1 kHz. With the default clock these periods are 720, 800, 1440 and 7200 cycles.
- R4: Code 4'h3 has the same period as 4'h2, and code 4'h7 has the same period as 4'h6.
- R5: Codes 4'hC to 4'hF select inhibit. While inhibit is active, `ref_o` stays 0.
- R6: A change of `sel_i` that is sampled at clock edge E restarts the division. The first pulse is high in the cycle after edge E+N, where N is the new period.
- R7: Each pulse on `ref_o` lasts exactly one cycle. It then repeats every N cycles for as long as the code is held.
- R8: `inhibit_o` follows the code sampled at the previous clock edge.
- R9: When the code leaves inhibit for an active code, the first pulse follows the timing of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-derived input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 4 | Reference rate select code |
| ref_o | output | 1 | One-cycle comparison pulse |
| inhibit_o | output | 1 | Backup state: feedback divider off, charge pump floating |

## Verification
The assertions check four things on every cycle: that each pulse is a single cycle long, that no pulse appears while inhibit is active, that the inhibit flag follows the code of the previous cycle, and that any code change clears the count.

The exact period for each of the sixteen codes can only be shown by the bench's scenarios. The same holds for the equal periods of the duplicate code pairs, the restart in the middle of a period, and the first pulse after inhibit is left.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

  localparam int unsigned CODE_W = 4;
  localparam int unsigned NCODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] sel_code_t;

  // comparison rate in units of 1/8 Hz; 0 marks inhibit
  function automatic longint unsigned rate_x8(input int unsigned code);
    case (code)
      0:       return 800000;
      1:       return 400000;
      2, 3:    return 200000;
      4:       return 100000;
      5:       return 50000;
      6, 7:    return 25000;
      8:       return 80000;
      9:       return 72000;
      10:      return 40000;
      11:      return 8000;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned div_ratio(input int unsigned clk_hz, input int unsigned code);
    longint unsigned r;
    r = rate_x8(code);
    if (r == 0) return 0;
    return int'((longint'(clk_hz) * 8) / r);
  endfunction

endpackage

// File: rtl/ref_code_decode.sv
module ref_code_decode
  import ref_sel_pkg::*;
#(
  parameter int unsigned CLK_HZ = 7200000,
  parameter int unsigned RW     = 13
) (
  input  sel_code_t       code_i,
  output logic [RW-1:0]   ratio_o,
  output logic            inhibit_o
);

  logic [RW-1:0] ratio_tbl [NCODES];
  logic [NCODES-1:0] inhib_tbl;

  for (genvar i = 0; i < NCODES; i++) begin : g_tbl
    localparam int unsigned RATIO = div_ratio(CLK_HZ, i);
    assign ratio_tbl[i] = RW'(RATIO);
    assign inhib_tbl[i] = (RATIO == 0);
  end

  assign ratio_o   = ratio_tbl[code_i];
  assign inhibit_o = inhib_tbl[code_i];

endmodule

// File: rtl/ref_div_counter.sv
module ref_div_counter #(
  parameter int unsigned RW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          hold_i,
  input  logic [RW-1:0] ratio_i,
  output logic          tick_o,
  output logic [RW-1:0] cnt_o
);

  logic [RW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == ratio_i - RW'(1));
  assign tick_o = last && !restart_i && !hold_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i || hold_i)   cnt_q <= '0;
    else if (last)                  cnt_q <= '0;
    else                            cnt_q <= cnt_q + RW'(1);
  end

endmodule

// File: rtl/ref_freq_sel.sv
module ref_freq_sel
  import ref_sel_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 7200000,
  parameter logic [3:0]  RST_CODE = 4'hF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sel_i,
  output logic       ref_o,
  output logic       inhibit_o
);

  localparam int unsigned MAX_RATIO = CLK_HZ / 1000;
  localparam int unsigned RW        = $clog2(MAX_RATIO + 1);

  sel_code_t     sel_q;
  logic          code_chg;
  logic [RW-1:0] ratio;
  logic          inhib;
  logic          tick;
  logic [RW-1:0] cnt_q;
  logic          ref_q;

  assign code_chg = (sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= RST_CODE;
      ref_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      ref_q <= tick;
    end
  end

  ref_code_decode #(.CLK_HZ(CLK_HZ), .RW(RW)) u_dec (
    .code_i    (sel_q),
    .ratio_o   (ratio),
    .inhibit_o (inhib)
  );

  ref_div_counter #(.RW(RW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (code_chg),
    .hold_i    (inhib),
    .ratio_i   (ratio),
    .tick_o    (tick),
    .cnt_o     (cnt_q)
  );

  assign ref_o     = ref_q;
  assign inhibit_o = inhib;

endmodule

// File: rtl/ref_freq_sel_chk.sv
module ref_freq_sel_chk #(
  parameter int unsigned RW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    sel_i,
  input logic          ref_o,
  input logic          inhibit_o,
  input logic [RW-1:0] cnt_i,
  input logic [RW-1:0] ratio_i
);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> !ref_o);

  a_r5_quiet_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o |-> !ref_o);

  a_r8_inhibit_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[3:2] == 2'b11) |=> inhibit_o);

  a_r8_active_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[3:2] != 2'b11) |=> !inhibit_o);

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_o |-> (cnt_i < ratio_i));

  a_r7_wrap_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> (cnt_i == '0));

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_i) |=> (cnt_i == '0 && !ref_o));

endmodule

bind ref_freq_sel ref_freq_sel_chk #(.RW(RW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .ref_o     (ref_o),
  .inhibit_o (inhibit_o),
  .cnt_i     (cnt_q),
  .ratio_i   (ratio)
);

// File: tb/tb_ref_freq_sel.sv
`timescale 1ns/1ps
module tb_ref_freq_sel;

  localparam int unsigned CLK_HZ = 7200000;
  localparam int          WD_CYC = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel_i = 4'hF;
  logic       ref_o;
  logic       inhibit_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int pulses = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "R7";

  always #2 clk_i = ~clk_i;

  ref_freq_sel #(.CLK_HZ(CLK_HZ)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i),
    .ref_o(ref_o), .inhibit_o(inhibit_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int exp_period(input logic [3:0] c);
    case (c)
      4'h0: return CLK_HZ / 100000;
      4'h1: return CLK_HZ / 50000;
      4'h2, 4'h3: return CLK_HZ / 25000;
      4'h4: return CLK_HZ * 2 / 25000;
      4'h5: return CLK_HZ * 4 / 25000;
      4'h6, 4'h7: return CLK_HZ * 8 / 25000;
      4'h8: return CLK_HZ / 10000;
      4'h9: return CLK_HZ / 9000;
      4'hA: return CLK_HZ / 5000;
      4'hB: return CLK_HZ / 1000;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of expected pulse cycles
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (ref_o) begin
        pulses++;
        if (exp_q.size() == 0) begin
          check({cur_tag, " unexpected pulse"}, cyc, -1);
        end else begin
          check({tag_q[0], " pulse cycle"}, cyc, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        check({tag_q[0], " missed pulse"}, 0, 1);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  // driver: apply code, queue k expected pulses, wait past the last
  task automatic run_code(input logic [3:0] c, input int k, input string tag);
    int n;
    int base;
    n = exp_period(c);
    @(negedge clk_i);
    sel_i = c;
    cur_tag = tag;
    base = cyc;
    for (int p = 1; p <= k; p++) begin
      exp_q.push_back(base + 1 + p * n);
      tag_q.push_back(tag);
    end
    @(negedge clk_i);
    check("R8 inhibit_o low after active code", int'(inhibit_o), 0);
    while (cyc < base + 2 + k * n) @(negedge clk_i);
    check({tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic run_inhibit(input logic [3:0] c, input int cycles);
    int p0;
    @(negedge clk_i);
    sel_i = c;
    cur_tag = "R5";
    @(negedge clk_i);
    check("R8 inhibit_o high after inhibit code", int'(inhibit_o), 1);
    p0 = pulses;
    repeat (cycles) @(negedge clk_i);
    check("R5 no pulses in inhibit", pulses - p0, 0);
    check("R5 inhibit_o held", int'(inhibit_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 ref_o in reset", int'(ref_o), 0);
    check("R1 inhibit_o in reset", int'(inhibit_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ref_o after reset", int'(ref_o), 0);
    check("R1 inhibit_o after reset", int'(inhibit_o), 1);
    mon_en = 1'b1;
    run_code(4'h0, 3, "R2 R7 code0");
    run_code(4'h1, 2, "R2 code1");
    run_code(4'h2, 2, "R2 code2");
    run_code(4'h3, 2, "R4 code3 dup of code2");
    run_code(4'h4, 2, "R2 code4");
    run_code(4'h5, 2, "R2 code5");
    run_code(4'h6, 2, "R2 code6");
    run_code(4'h7, 2, "R4 code7 dup of code6");
    run_code(4'h8, 2, "R3 code8");
    run_code(4'h9, 2, "R3 code9");
    run_code(4'hA, 2, "R3 codeA");
    run_code(4'hB, 1, "R3 codeB");
    // mid-period restart
    @(negedge clk_i);
    sel_i = 4'h0;
    repeat (40) @(negedge clk_i);
    run_code(4'h1, 2, "R6 restart mid period");
    run_inhibit(4'hC, 300);
    run_inhibit(4'hD, 100);
    run_inhibit(4'hE, 100);
    run_inhibit(4'hF, 100);
    run_code(4'h0, 2, "R9 leave inhibit");
    run_inhibit(4'hC, 50);
    run_code(4'h8, 1, "R9 leave inhibit code8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYC);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule